// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block owns the command bus of a single-data-rate SDRAM from reset until the memory is ready for normal traffic. While reset is held, and throughout the start-up sequence, it keeps clock enable and the data mask high and drives the no-operation code on the command pins. After a settle interval of a programmable number of clock cycles, it closes every open row with a precharge-all command. It then programs the mode register with a configurable opcode and issues a configurable number of auto-refresh commands. A parameter sets which of these two steps runs first. Each command is followed by its own parameterized run of no-operation cycles.

When the last wait has elapsed, the block raises a sticky done flag. From that point its outputs follow the command inputs of the normal memory controller, which is attached to the user-side ports. Before done, those inputs have no effect on the bus. Periodic refresh, read and write traffic and the data path belong to other logic.

Top module: `sdram_startup`

## Requirements
- R1: From reset until `initDone` is high, `cke` and `dqm` are both driven 1.
- R2: Before `initDone`, every cycle that carries no start-up command carries no-operation: `csN`=0 and `rasN`=`casN`=`weN`=1. This includes every cycle of the settle interval.
- R3: The first command is precharge-all, encoded `csN`=0, `rasN`=0, `casN`=1, `weN`=0. It appears in the cycle after the SETTLE_CYCLES-th rising clock edge that follows reset release.
- R4: During the precharge-all cycle, `addr[10]` is 1.
- R5: The mode register set is encoded with `csN`, `rasN`, `casN` and `weN` all 0. During that cycle `addr[11:0]` equals MODE_OPCODE and `ba` is 0.
- R6: Exactly REFRESH_COUNT auto-refresh commands are issued before done, each encoded `csN`=`rasN`=`casN`=0 and `weN`=1.
- R7: When MODE_FIRST is 1, the mode register set comes before the first refresh. When it is 0, it comes after the last refresh.
- R8: Commands are spaced by their waits. After a precharge-all, a mode register set or a refresh, the next command appears TRP_CYCLES+1, TMRD_CYCLES+1 or TRFC_CYCLES+1 cycles later, respectively.
- R9: `initDone` rises WAIT+1 cycles after the last command, where WAIT is that command's wait. It then stays high until the next reset.
- R10: Once `initDone` is high, every bus output equals its `user*` input in the same cycle. Before that, the `user*` inputs have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| userCke | input | 1 | Clock enable from normal logic, passed through after done |
| userDqm | input | 1 | Data mask from normal logic, passed through after done |
| userCsN | input | 1 | Chip select from normal logic |
| userRasN | input | 1 | Row strobe from normal logic |
| userCasN | input | 1 | Column strobe from normal logic |
| userWeN | input | 1 | Write enable from normal logic |
| userAddr | input | ADDR_W | Address from normal logic |
| userBa | input | BANK_W | Bank select from normal logic |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| csN | output | 1 | Chip select to the memory |
| rasN | output | 1 | Row strobe to the memory |
| casN | output | 1 | Column strobe to the memory |
| weN | output | 1 | Write enable to the memory |
| addr | output | ADDR_W | Address to the memory |
| ba | output | BANK_W | Bank select to the memory |
| initDone | output | 1 | Start-up sequence complete (sticky) |

## Verification
The bench builds two instances.

- **`uut`**: mode register first, a 40-cycle settle interval, waits of 2, 3 and 5 cycles, eight refreshes and opcode 0x237.
- **`uutAlt`**: refresh burst first, a 25-cycle settle interval, waits of 2, 3 and 4 cycles, eight refreshes and opcode 0x0A5.

The short settle intervals bring the whole sequence and the hand-off within about a hundred cycles. The three waits in each build are all different, so a command spaced by the wrong wait lands on a cycle the bench can tell apart. Building both orders exercises each branch of the order selection, and it places the done flag after a refresh in one build and after the mode register set in the other.

// File: rtl/sdram_startup_pkg.sv
`timescale 1ns/1ps
package sdram_startup_pkg;

  // One-cycle strobes from the sequencing control into the datapath.
  typedef struct packed {
    logic issuePre;
    logic issueMode;
    logic issueRef;
    logic setDone;
  } seqStrobes_t;

  typedef enum logic [2:0] {
    ST_SETTLE    = 3'd0,
    ST_PRE_WAIT  = 3'd1,
    ST_MODE_WAIT = 3'd2,
    ST_REF_WAIT  = 3'd3,
    ST_FINISHED  = 3'd4
  } seqState_t;

  function automatic int maxOf2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/startup_ctrl.sv
`timescale 1ns/1ps
module startup_ctrl
  import sdram_startup_pkg::*;
#(
  parameter int MODE_FIRST = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        waitZero,
  input  logic        refsDone,
  output seqStrobes_t strobes
);

  localparam bit MODE_LEADS = (MODE_FIRST != 0);

  seqState_t state;
  seqState_t nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      ST_SETTLE: begin
        if (waitZero) begin
          strobes.issuePre = 1'b1;
          nextState        = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (waitZero) begin
          if (MODE_LEADS) begin
            strobes.issueMode = 1'b1;
            nextState         = ST_MODE_WAIT;
          end else begin
            strobes.issueRef = 1'b1;
            nextState        = ST_REF_WAIT;
          end
        end
      end
      ST_MODE_WAIT: begin
        if (waitZero) begin
          if (MODE_LEADS) begin
            strobes.issueRef = 1'b1;
            nextState        = ST_REF_WAIT;
          end else begin
            strobes.setDone = 1'b1;
            nextState       = ST_FINISHED;
          end
        end
      end
      ST_REF_WAIT: begin
        if (waitZero) begin
          if (!refsDone) begin
            strobes.issueRef = 1'b1;
          end else if (MODE_LEADS) begin
            strobes.setDone = 1'b1;
            nextState       = ST_FINISHED;
          end else begin
            strobes.issueMode = 1'b1;
            nextState         = ST_MODE_WAIT;
          end
        end
      end
      ST_FINISHED: nextState = ST_FINISHED;
      default:     nextState = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SETTLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/startup_datapath.sv
`timescale 1ns/1ps
module startup_datapath
  import sdram_startup_pkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter int          BANK_W        = 2,
  parameter int          SETTLE_CYCLES = 40000,
  parameter int          TRP_CYCLES    = 3,
  parameter int          TMRD_CYCLES   = 2,
  parameter int          TRFC_CYCLES   = 7,
  parameter int          REFRESH_COUNT = 8,
  parameter logic [11:0] MODE_OPCODE   = 12'h023
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  output logic              waitZero,
  output logic              refsDone,
  output logic              seqCsN,
  output logic              seqRasN,
  output logic              seqCasN,
  output logic              seqWeN,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [BANK_W-1:0] seqBa,
  output logic              doneFlag
);

  localparam int MAX_WAIT = maxOf2(maxOf2(SETTLE_CYCLES - 1, TRP_CYCLES),
                                   maxOf2(TMRD_CYCLES, TRFC_CYCLES));
  localparam int CNT_W = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
  localparam int REF_W = (REFRESH_COUNT < 1) ? 1 : $clog2(REFRESH_COUNT + 1);
  localparam logic [ADDR_W-1:0] PRECH_WORD = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MODE_WORD  = ADDR_W'(MODE_OPCODE);

  logic [CNT_W-1:0] waitCnt;
  logic [REF_W-1:0] refsLeft;

  // Shared wait counter: reloaded by every issued command, counts down to 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= CNT_W'(SETTLE_CYCLES - 1);
    end else if (strobes.issuePre) begin
      waitCnt <= CNT_W'(TRP_CYCLES);
    end else if (strobes.issueMode) begin
      waitCnt <= CNT_W'(TMRD_CYCLES);
    end else if (strobes.issueRef) begin
      waitCnt <= CNT_W'(TRFC_CYCLES);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refsLeft <= REF_W'(REFRESH_COUNT);
    end else if (strobes.issueRef && refsLeft != '0) begin
      refsLeft <= refsLeft - 1'b1;
    end
  end

  assign waitZero = (waitCnt == '0);
  assign refsDone = (refsLeft == '0);

  // Registered command bus: idle code unless a strobe selects a command.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCsN  <= 1'b0;
      seqRasN <= 1'b1;
      seqCasN <= 1'b1;
      seqWeN  <= 1'b1;
      seqAddr <= '0;
      seqBa   <= '0;
    end else begin
      seqCsN  <= 1'b0;
      seqRasN <= 1'b1;
      seqCasN <= 1'b1;
      seqWeN  <= 1'b1;
      seqAddr <= '0;
      seqBa   <= '0;
      if (strobes.issuePre) begin
        seqRasN <= 1'b0;
        seqWeN  <= 1'b0;
        seqAddr <= PRECH_WORD;
      end else if (strobes.issueMode) begin
        seqRasN <= 1'b0;
        seqCasN <= 1'b0;
        seqWeN  <= 1'b0;
        seqAddr <= MODE_WORD;
      end else if (strobes.issueRef) begin
        seqRasN <= 1'b0;
        seqCasN <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                doneFlag <= 1'b0;
    else if (strobes.setDone) doneFlag <= 1'b1;
  end

endmodule

// File: rtl/sdram_startup.sv
`timescale 1ns/1ps
module sdram_startup
  import sdram_startup_pkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter int          BANK_W        = 2,
  parameter int          SETTLE_CYCLES = 40000,
  parameter int          TRP_CYCLES    = 3,
  parameter int          TMRD_CYCLES   = 2,
  parameter int          TRFC_CYCLES   = 7,
  parameter int          REFRESH_COUNT = 8,
  parameter int          MODE_FIRST    = 1,
  parameter logic [11:0] MODE_OPCODE   = 12'h023
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              userCke,
  input  logic              userDqm,
  input  logic              userCsN,
  input  logic              userRasN,
  input  logic              userCasN,
  input  logic              userWeN,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [BANK_W-1:0] userBa,
  output logic              cke,
  output logic              dqm,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              initDone
);

  seqStrobes_t       strobes;
  logic              waitZero;
  logic              refsDone;
  logic              seqCsN;
  logic              seqRasN;
  logic              seqCasN;
  logic              seqWeN;
  logic [ADDR_W-1:0] seqAddr;
  logic [BANK_W-1:0] seqBa;
  logic              doneFlag;

  startup_ctrl #(
    .MODE_FIRST (MODE_FIRST)
  ) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .waitZero (waitZero),
    .refsDone (refsDone),
    .strobes  (strobes)
  );

  startup_datapath #(
    .ADDR_W        (ADDR_W),
    .BANK_W        (BANK_W),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .TRP_CYCLES    (TRP_CYCLES),
    .TMRD_CYCLES   (TMRD_CYCLES),
    .TRFC_CYCLES   (TRFC_CYCLES),
    .REFRESH_COUNT (REFRESH_COUNT),
    .MODE_OPCODE   (MODE_OPCODE)
  ) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .waitZero (waitZero),
    .refsDone (refsDone),
    .seqCsN   (seqCsN),
    .seqRasN  (seqRasN),
    .seqCasN  (seqCasN),
    .seqWeN   (seqWeN),
    .seqAddr  (seqAddr),
    .seqBa    (seqBa),
    .doneFlag (doneFlag)
  );

  // Hand-off: the sequencer owns the bus until done, normal logic after.
  assign initDone = doneFlag;
  assign cke  = doneFlag ? userCke  : 1'b1;
  assign dqm  = doneFlag ? userDqm  : 1'b1;
  assign csN  = doneFlag ? userCsN  : seqCsN;
  assign rasN = doneFlag ? userRasN : seqRasN;
  assign casN = doneFlag ? userCasN : seqCasN;
  assign weN  = doneFlag ? userWeN  : seqWeN;
  assign addr = doneFlag ? userAddr : seqAddr;
  assign ba   = doneFlag ? userBa   : seqBa;

endmodule

// File: rtl/sdram_startup_checker.sv
`timescale 1ns/1ps
module sdram_startup_checker #(
  parameter int          ADDR_W        = 12,
  parameter int          BANK_W        = 2,
  parameter int          REFRESH_COUNT = 8,
  parameter logic [11:0] MODE_OPCODE   = 12'h023
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              dqm,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic              initDone
);

  logic        isIdle;
  logic        isPre;
  logic        isMode;
  logic        isRef;
  logic [15:0] refTally;

  assign isIdle = !csN && rasN && casN && weN;
  assign isPre  = !csN && !rasN && casN && !weN;
  assign isMode = !csN && !rasN && !casN && !weN;
  assign isRef  = !csN && !rasN && !casN && weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 refTally <= '0;
    else if (!initDone && isRef) refTally <= refTally + 16'd1;
  end

  AST_HOLD_CKE_DQM: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (cke && dqm)) else $error("cke/dqm dropped before done"); // R1

  AST_PRECH_A10: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone && isPre) |-> addr[10]) else $error("precharge without A10"); // R4

  AST_MODE_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone && isMode) |-> (addr[11:0] == MODE_OPCODE && ba == '0))
    else $error("mode opcode wrong"); // R5

  AST_REF_TALLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (refTally == 16'(REFRESH_COUNT)))
    else $error("refresh count wrong at done"); // R6

  AST_CMD_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone && !isIdle) |=> (initDone || isIdle))
    else $error("command not followed by idle"); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone) else $error("done fell"); // R9

endmodule

bind sdram_startup sdram_startup_checker #(
  .ADDR_W        (ADDR_W),
  .BANK_W        (BANK_W),
  .REFRESH_COUNT (REFRESH_COUNT),
  .MODE_OPCODE   (MODE_OPCODE)
) startupChk (
  .clk      (clk),
  .rstN     (rstN),
  .cke      (cke),
  .dqm      (dqm),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .addr     (addr),
  .ba       (ba),
  .initDone (initDone)
);

// File: tb/sdram_startup_test.sv
`timescale 1ns/1ps
module sdram_startup_test;

  localparam int LOGN = 110;
  // Build A: mode register first
  localparam int          A_SETTLE = 40, A_TRP = 2, A_TMRD = 3, A_TRFC = 5, A_NREF = 8;
  localparam logic [11:0] A_OP = 12'h237;
  // Build B: refresh burst first
  localparam int          B_SETTLE = 25, B_TRP = 2, B_TMRD = 3, B_TRFC = 4, B_NREF = 8;
  localparam logic [11:0] B_OP = 12'h0A5;

  localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_MRS = 3'd2, C_REF = 3'd3, C_OTH = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic userCke, userDqm, userCsN, userRasN, userCasN, userWeN;
  logic [11:0] userAddr;
  logic [1:0]  userBa;

  logic aCke, aDqm, aCsN, aRasN, aCasN, aWeN, aDone;
  logic [11:0] aAddr;
  logic [1:0]  aBa;
  logic bCke, bDqm, bCsN, bRasN, bCasN, bWeN, bDone;
  logic [11:0] bAddr;
  logic [1:0]  bBa;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [2:0]  logCode [2][0:LOGN];
  logic [11:0] logAddr [2][0:LOGN];
  logic [1:0]  logBa   [2][0:LOGN];
  logic        logDone [2][0:LOGN];
  logic        logHold [2][0:LOGN];
  logic [2:0]  expCode [0:LOGN];

  always #2.5 clk = ~clk;

  sdram_startup #(
    .ADDR_W(12), .BANK_W(2), .SETTLE_CYCLES(A_SETTLE), .TRP_CYCLES(A_TRP),
    .TMRD_CYCLES(A_TMRD), .TRFC_CYCLES(A_TRFC), .REFRESH_COUNT(A_NREF),
    .MODE_FIRST(1), .MODE_OPCODE(A_OP)
  ) uut (
    .clk(clk), .rstN(rstN), .userCke(userCke), .userDqm(userDqm),
    .userCsN(userCsN), .userRasN(userRasN), .userCasN(userCasN), .userWeN(userWeN),
    .userAddr(userAddr), .userBa(userBa), .cke(aCke), .dqm(aDqm), .csN(aCsN),
    .rasN(aRasN), .casN(aCasN), .weN(aWeN), .addr(aAddr), .ba(aBa), .initDone(aDone)
  );

  sdram_startup #(
    .ADDR_W(12), .BANK_W(2), .SETTLE_CYCLES(B_SETTLE), .TRP_CYCLES(B_TRP),
    .TMRD_CYCLES(B_TMRD), .TRFC_CYCLES(B_TRFC), .REFRESH_COUNT(B_NREF),
    .MODE_FIRST(0), .MODE_OPCODE(B_OP)
  ) uutAlt (
    .clk(clk), .rstN(rstN), .userCke(userCke), .userDqm(userDqm),
    .userCsN(userCsN), .userRasN(userRasN), .userCasN(userCasN), .userWeN(userWeN),
    .userAddr(userAddr), .userBa(userBa), .cke(bCke), .dqm(bDqm), .csN(bCsN),
    .rasN(bRasN), .casN(bCasN), .weN(bWeN), .addr(bAddr), .ba(bBa), .initDone(bDone)
  );

  function automatic logic [2:0] decode(input logic cs, input logic ras,
                                        input logic cas, input logic we);
    if (cs) return C_OTH;
    case ({ras, cas, we})
      3'b111:  return C_NOP;
      3'b010:  return C_PRE;
      3'b000:  return C_MRS;
      3'b001:  return C_REF;
      default: return C_OTH;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    userCke = 1'b0; userDqm = 1'b0; userCsN = 1'b0; userRasN = 1'b0;
    userCasN = 1'b0; userWeN = 1'b0; userAddr = 12'hFFF; userBa = 2'b11;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(aCke && aDqm && bCke && bDqm, "R1", "cke/dqm high in reset",
          {aCke, aDqm, bCke, bDqm}, 15);
    check(decode(aCsN, aRasN, aCasN, aWeN) == C_NOP && decode(bCsN, bRasN, bCasN, bWeN) == C_NOP,
          "R10", "idle bus in reset despite user command",
          decode(aCsN, aRasN, aCasN, aWeN), C_NOP);
    check(!aDone && !bDone, "R9", "done low in reset", {aDone, bDone}, 0);
  endtask

  task automatic recordRun();
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 1; i <= LOGN; i++) begin
      @(negedge clk);
      logCode[0][i] = decode(aCsN, aRasN, aCasN, aWeN);
      logAddr[0][i] = aAddr; logBa[0][i] = aBa; logDone[0][i] = aDone;
      logHold[0][i] = aCke && aDqm;
      logCode[1][i] = decode(bCsN, bRasN, bCasN, bWeN);
      logAddr[1][i] = bAddr; logBa[1][i] = bBa; logDone[1][i] = bDone;
      logHold[1][i] = bCke && bDqm;
    end
  endtask

  task automatic analyze(input int w, input bit modeFirst, input int settle, input int trp,
                         input int tmrd, input int trfc, input int nref, input logic [11:0] op);
    int t, doneAt, badIdle, badHold, refSeen, mrsAt, firstRef, lastRef;
    for (int i = 0; i <= LOGN; i++) expCode[i] = C_NOP;
    t = settle;
    expCode[t] = C_PRE;
    check(logCode[w][t] == C_PRE, "R3", $sformatf("dut%0d precharge position", w), logCode[w][t], C_PRE);
    check(logAddr[w][t][10] == 1'b1, "R4", $sformatf("dut%0d precharge addr[10]", w), logAddr[w][t][10], 1);
    t += trp + 1;
    if (modeFirst) begin
      expCode[t] = C_MRS; t += tmrd + 1;
      for (int k = 0; k < nref; k++) begin expCode[t] = C_REF; t += trfc + 1; end
    end else begin
      for (int k = 0; k < nref; k++) begin expCode[t] = C_REF; t += trfc + 1; end
      expCode[t] = C_MRS; t += tmrd + 1;
    end
    doneAt = t;
    badIdle = 0; badHold = 0; refSeen = 0; mrsAt = -1; firstRef = -1; lastRef = -1;
    for (int i = 1; i < doneAt; i++) begin
      if (expCode[i] == C_NOP && logCode[w][i] != C_NOP) badIdle++;
      if (!logHold[w][i]) badHold++;
      if (logCode[w][i] == C_REF) begin
        refSeen++; lastRef = i; if (firstRef < 0) firstRef = i;
      end
      if (logCode[w][i] == C_MRS) begin
        mrsAt = i;
        check(logAddr[w][i] == op && logBa[w][i] == 2'b00, "R5",
              $sformatf("dut%0d mode opcode", w), logAddr[w][i], op);
      end
      if (expCode[i] == C_REF)
        check(logCode[w][i] == C_REF, "R8", $sformatf("dut%0d refresh at cycle %0d", w, i),
              logCode[w][i], C_REF);
      if (expCode[i] == C_MRS)
        check(logCode[w][i] == C_MRS, "R8", $sformatf("dut%0d mode set at cycle %0d", w, i),
              logCode[w][i], C_MRS);
    end
    check(badIdle == 0, "R2", $sformatf("dut%0d non-idle cycles outside commands", w), badIdle, 0);
    check(badHold == 0, "R1", $sformatf("dut%0d cycles with cke/dqm low", w), badHold, 0);
    check(refSeen == nref, "R6", $sformatf("dut%0d refresh count", w), refSeen, nref);
    check(mrsAt >= 0 && (modeFirst ? (mrsAt < firstRef) : (mrsAt > lastRef)), "R7",
          $sformatf("dut%0d mode set order", w), mrsAt, modeFirst ? firstRef - 1 : lastRef + 1);
    check(logDone[w][doneAt - 1] == 1'b0 && logDone[w][doneAt] == 1'b1, "R9",
          $sformatf("dut%0d done edge at cycle %0d", w, doneAt),
          {logDone[w][doneAt - 1], logDone[w][doneAt]}, 1);
    for (int i = doneAt; i <= LOGN; i++)
      if (!logDone[w][i]) begin
        check(1'b0, "R9", $sformatf("dut%0d done fell at cycle %0d", w, i), 0, 1);
        break;
      end
  endtask

  task automatic testHandoff();
    logic [19:0] pat;
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      pat = (p == 0) ? 20'hA5C3F : ((p == 1) ? 20'h3A0C6 : 20'hFFFFF);
      {userCke, userDqm, userCsN, userRasN, userCasN, userWeN, userAddr, userBa} = pat;
      #1;
      check({aCke, aDqm, aCsN, aRasN, aCasN, aWeN, aAddr, aBa} == pat, "R10",
            "uut bus follows user inputs", {aCke, aDqm, aCsN, aRasN, aCasN, aWeN, aAddr, aBa}, pat);
      check({bCke, bDqm, bCsN, bRasN, bCasN, bWeN, bAddr, bBa} == pat, "R10",
            "uutAlt bus follows user inputs", {bCke, bDqm, bCsN, bRasN, bCasN, bWeN, bAddr, bBa}, pat);
      check(aDone && bDone, "R9", "done held during hand-off", {aDone, bDone}, 3);
    end
  endtask

  initial begin
    testReset();
    recordRun();
    analyze(0, 1'b1, A_SETTLE, A_TRP, A_TMRD, A_TRFC, A_NREF, A_OP);
    analyze(1, 1'b0, B_SETTLE, B_TRP, B_TMRD, B_TRFC, B_NREF, B_OP);
    testHandoff();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule